// File: doc/BRIEF.md
# Bayer Black Level Correction Stage

This stage sits early in a raw camera pipeline. It takes a single-plane color filter array pixel stream, one pixel per clock on a valid/ready handshake with start-of-frame and end-of-line markers. Each pixel is assigned to one of four channels from its row parity, its column parity and a programmable 2-bit layout phase. The channel's black pedestal is subtracted from the pixel. A result below zero is either mirrored to its magnitude or forced to zero. The corrected value is then multiplied by the channel's unsigned fractional gain, rounded, and saturated to the output width.

Settings are written through a small memory-mapped register port. Control, pedestal and gain registers land in shadow copies. A write to the commit address marks them pending, and they become active at the next start of frame, so a frame is never processed with mixed settings. Software can read a frame-active flag, the pending flag and an 8-bit checksum of the last completed output frame.

Top module: `bayer_blc`

## Requirements
- R1: After reset the output is not valid, `s_ready` is 1, the status word at 0x0C reads 0, and the identification word at 0x00 reads 0x6FA70177.
- R2: For a pixel at row parity r and column parity c, the channel index is {r,c} XOR phase, where phase is control bits [2:1]. Row parity is 0 on the start-of-frame pixel and toggles after each end-of-line. Column parity is 0 on the first pixel of each line.
- R3: With bypass clear, the output is floor((corrected * gain + 2^17) / 2^18), saturated to the output width. Gain is an 18-bit unsigned fraction whose LSB weighs 2^-18. Channel c keeps its pedestal at 0x20+8c and its gain at 0x24+8c.
- R4: A pixel below its pedestal yields the pedestal minus the pixel (reflect build). When control bit 3 (clip) is set, it yields 0 instead.
- R5: When control bit 0 (bypass) is set, each pixel leaves unchanged.
- R6: Writes to the control register (0x18), the pedestals and the gains change no output until a write to 0x14 (commit) is made and a start-of-frame pixel is then accepted. A commit made mid-frame leaves the rest of that frame unchanged. Status bit 1 reads 1 while a commit is pending.
- R7: Status bit 1 clears when the pending settings are applied at a start of frame.
- R8: Status bit 0 is 1 from the output start-of-frame transfer until the output end-of-line that completes the line count held in the height register (0x08).
- R9: The word at 0x10 holds the modulo-256 sum of all output samples of the last completed frame. It is updated at that frame's final end-of-line transfer.
- R10: `s_ready` equals not `m_valid` or `m_ready`. A stalled output holds its data and markers. Markers leave with their own pixel, one cycle after acceptance.
- R11: Width (0x04) and height (0x08) are 16-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_data | input | IN_W | Input raw sample |
| s_sof | input | 1 | Input pixel is first of a frame |
| s_eol | input | 1 | Input pixel is last of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts output pixel |
| m_data | output | OUT_W | Corrected sample |
| m_sof | output | 1 | Output pixel is first of a frame |
| m_eol | output | 1 | Output pixel is last of a line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |

## Verification
The assertions assume that start-of-frame marks only the first pixel of a frame and that every frame carries exactly as many lines as the height register holds. They also assume that the register port does not alter the height while a frame is in flight. The bench builds each frame of exactly four lines of random length and writes the height before any frame. It fires mid-frame commits only on pixels that are not start-of-frame. Stalls are drawn at random on both sides of the handshake.

// File: rtl/blc_pkg.sv
package blc_pkg;

    typedef struct packed {
        logic       clip_zero;   // bit 3
        logic [1:0] phase;       // bits 2:1
        logic       bypass;      // bit 0
    } blc_ctrl_t;

    localparam logic [31:0] BLC_ID = 32'h6FA7_0177;

    localparam int NUM_CH    = 4;
    localparam int A_ID      = 'h00;
    localparam int A_WIDTH   = 'h04;
    localparam int A_HEIGHT  = 'h08;
    localparam int A_STATUS  = 'h0C;
    localparam int A_CKSUM   = 'h10;
    localparam int A_COMMIT  = 'h14;
    localparam int A_CTRL    = 'h18;
    localparam int A_CH_BASE = 'h20;
    localparam int CH_STRIDE = 8;
    localparam int A_CH_END  = A_CH_BASE + NUM_CH * CH_STRIDE;

endpackage

// File: rtl/blc_regs.sv
module blc_regs
    import blc_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int SCL_W  = 18,
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 16,
    parameter int DEF_W  = 640,
    parameter int DEF_H  = 480
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          frame_start,
    input  logic                          stat_running,
    input  logic [7:0]                    stat_cksum,
    output blc_ctrl_t                     use_ctrl,
    output logic [NUM_CH-1:0][IN_W-1:0]   use_ped,
    output logic [NUM_CH-1:0][SCL_W-1:0]  use_scl,
    output logic [DIM_W-1:0]              img_height
);

    typedef struct packed {
        blc_ctrl_t                        sh_ctl;
        blc_ctrl_t                        ac_ctl;
        logic [NUM_CH-1:0][IN_W-1:0]      sh_ped;
        logic [NUM_CH-1:0][IN_W-1:0]      ac_ped;
        logic [NUM_CH-1:0][SCL_W-1:0]     sh_scl;
        logic [NUM_CH-1:0][SCL_W-1:0]     ac_scl;
        logic [DIM_W-1:0]                 width;
        logic [DIM_W-1:0]                 height;
        logic                             pend;
    } regs_t;

    regs_t st_d, st_q;

    logic              apply;
    logic              in_ch;
    logic              commit_wr;
    logic [ADDR_W-1:0] ch_off;
    logic [1:0]        ch_idx;

    assign ch_off    = reg_addr - ADDR_W'(A_CH_BASE);
    assign ch_idx    = ch_off[4:3];
    assign in_ch     = (reg_addr >= ADDR_W'(A_CH_BASE)) && (reg_addr < ADDR_W'(A_CH_END));
    assign commit_wr = reg_we && (reg_addr == ADDR_W'(A_COMMIT));
    assign apply     = frame_start && st_q.pend;

    always_comb begin
        st_d = st_q;
        if (apply) begin
            st_d.ac_ctl = st_q.sh_ctl;
            st_d.ac_ped = st_q.sh_ped;
            st_d.ac_scl = st_q.sh_scl;
            st_d.pend   = 1'b0;
        end
        if (reg_we) begin
            if (reg_addr == ADDR_W'(A_WIDTH)) begin
                st_d.width = reg_wdata[DIM_W-1:0];
            end else if (reg_addr == ADDR_W'(A_HEIGHT)) begin
                st_d.height = reg_wdata[DIM_W-1:0];
            end else if (reg_addr == ADDR_W'(A_COMMIT)) begin
                st_d.pend = 1'b1;
            end else if (reg_addr == ADDR_W'(A_CTRL)) begin
                st_d.sh_ctl = reg_wdata[3:0];
            end else if (in_ch) begin
                if (ch_off[2]) begin
                    st_d.sh_scl[ch_idx] = reg_wdata[SCL_W-1:0];
                end else begin
                    st_d.sh_ped[ch_idx] = reg_wdata[IN_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.width  <= DIM_W'(DEF_W);
            st_q.height <= DIM_W'(DEF_H);
        end else begin
            st_q <= st_d;
        end
    end

    // the frame that triggers the commit already sees the new set
    assign use_ctrl   = apply ? st_q.sh_ctl : st_q.ac_ctl;
    assign use_ped    = apply ? st_q.sh_ped : st_q.ac_ped;
    assign use_scl    = apply ? st_q.sh_scl : st_q.ac_scl;
    assign img_height = st_q.height;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_ID)) begin
            reg_rdata = BLC_ID;
        end else if (reg_addr == ADDR_W'(A_WIDTH)) begin
            reg_rdata = 32'(st_q.width);
        end else if (reg_addr == ADDR_W'(A_HEIGHT)) begin
            reg_rdata = 32'(st_q.height);
        end else if (reg_addr == ADDR_W'(A_STATUS)) begin
            reg_rdata = {30'd0, st_q.pend, stat_running};
        end else if (reg_addr == ADDR_W'(A_CKSUM)) begin
            reg_rdata = {24'd0, stat_cksum};
        end else if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata = 32'(st_q.sh_ctl);
        end else if (in_ch) begin
            reg_rdata = ch_off[2] ? 32'(st_q.sh_scl[ch_idx]) : 32'(st_q.sh_ped[ch_idx]);
        end
    end

    logic unused_bits;
    assign unused_bits = ^{reg_wdata, ch_off};

    AST_COMMIT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> st_q.pend) else $error("commit did not set pending"); // R6
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && st_q.pend && !commit_wr |=> !st_q.pend) else $error("pending not cleared"); // R7
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(st_q.ac_ped) && $stable(st_q.ac_scl) && $stable(st_q.ac_ctl)))
        else $error("active set changed outside start of frame"); // R6

endmodule

// File: rtl/blc_chan.sv
module blc_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       sof,
    input  logic       eol,
    input  logic [1:0] phase,
    output logic [1:0] ch
);

    typedef struct packed {
        logic row;
        logic col;
    } par_t;

    par_t st_d, st_q;
    logic cur_row, cur_col;

    assign cur_row = sof ? 1'b0 : st_q.row;
    assign cur_col = sof ? 1'b0 : st_q.col;
    assign ch      = {cur_row, cur_col} ^ phase;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.col = eol ? 1'b0 : ~cur_col;
            st_d.row = eol ? ~cur_row : cur_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SOF_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        fire && sof && !eol |=> (!st_q.row && st_q.col)) else $error("parity after sof"); // R2
    AST_EOL_COL: assert property (@(posedge clk) disable iff (!rst_n)
        fire && eol |=> !st_q.col) else $error("column parity after eol"); // R2

endmodule

// File: rtl/blc_correct.sv
module blc_correct
    import blc_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int OUT_W   = 12,
    parameter int SCL_W   = 18,
    parameter bit REFLECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [IN_W-1:0]   s_data,
    input  logic              s_sof,
    input  logic              s_eol,
    input  logic [IN_W-1:0]   ped,
    input  logic [SCL_W-1:0]  scl,
    input  blc_ctrl_t         ctrl,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [OUT_W-1:0]  m_data,
    output logic              m_sof,
    output logic              m_eol
);

    localparam int PW = IN_W + SCL_W;
    localparam int XW = (OUT_W > IN_W + 1) ? OUT_W : IN_W + 1;
    localparam logic [XW-1:0] OMAX = XW'((64'd1 << OUT_W) - 64'd1);
    localparam logic [PW:0]   HALF = (PW+1)'(1) << (SCL_W - 1);

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
        logic             sof;
        logic             eol;
    } out_t;

    out_t st_d, st_q;

    logic              s_fire;
    logic              below;
    logic [IN_W-1:0]   pos_diff, neg_diff, corr;
    logic [PW-1:0]     prod;
    logic [PW:0]       rnd;
    logic [XW-1:0]     pick;
    logic [OUT_W-1:0]  result;

    assign below    = s_data < ped;
    assign pos_diff = s_data - ped;
    assign neg_diff = ped - s_data;

    if (REFLECT) begin : g_reflect
        assign corr = below ? (ctrl.clip_zero ? '0 : neg_diff) : pos_diff;
    end else begin : g_clip
        logic unused_clip;
        assign unused_clip = ctrl.clip_zero ^ (|neg_diff);
        assign corr = below ? '0 : pos_diff;
    end

    assign prod   = PW'(corr) * PW'(scl);
    assign rnd    = {1'b0, prod} + HALF;
    assign pick   = ctrl.bypass ? XW'(s_data) : XW'(rnd[PW:SCL_W]);
    assign result = (pick > OMAX) ? OMAX[OUT_W-1:0] : pick[OUT_W-1:0];

    assign s_ready = !st_q.valid || m_ready;
    assign s_fire  = s_valid && s_ready;

    always_comb begin
        st_d = st_q;
        if (s_fire) begin
            st_d.valid = 1'b1;
            st_d.data  = result;
            st_d.sof   = s_sof;
            st_d.eol   = s_eol;
        end else if (m_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_valid = st_q.valid;
    assign m_data  = st_q.data;
    assign m_sof   = st_q.sof;
    assign m_eol   = st_q.eol;

    logic unused_rnd;
    assign unused_rnd = ^rnd[SCL_W-1:0];

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol))
        else $error("stalled output changed"); // R10
    AST_CLIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_fire && !ctrl.bypass && ctrl.clip_zero && (s_data < ped) |=> m_data == '0)
        else $error("clip did not give zero"); // R4

    if (OUT_W >= IN_W) begin : g_byp_chk
        AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            s_fire && ctrl.bypass |=> m_data == OUT_W'($past(s_data)))
            else $error("bypass altered pixel"); // R5
    end

endmodule

// File: rtl/blc_frame_mon.sv
module blc_frame_mon #(
    parameter int OUT_W = 12,
    parameter int DIM_W = 16,
    parameter int CK_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             sof,
    input  logic             eol,
    input  logic [OUT_W-1:0] data,
    input  logic [DIM_W-1:0] height,
    output logic             running,
    output logic [CK_W-1:0]  cksum
);

    typedef struct packed {
        logic             running;
        logic [DIM_W-1:0] line;
        logic [CK_W-1:0]  sum;
        logic [CK_W-1:0]  cks;
    } mon_t;

    mon_t st_d, st_q;

    logic [DIM_W-1:0] cur_line;
    logic [CK_W-1:0]  cur_sum;
    logic [DIM_W:0]   lines_done;
    logic             last;

    assign cur_line   = sof ? '0 : st_q.line;
    assign cur_sum    = (sof ? '0 : st_q.sum) + CK_W'(data);
    assign lines_done = {1'b0, cur_line} + (DIM_W+1)'(1);
    assign last       = eol && (lines_done >= {1'b0, height});

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.sum = cur_sum;
            if (sof) st_d.running = 1'b1;
            if (eol) begin
                if (last) begin
                    st_d.running = 1'b0;
                    st_d.cks     = cur_sum;
                    st_d.line    = '0;
                end else begin
                    st_d.line    = lines_done[DIM_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.running;
    assign cksum   = st_q.cks;

    logic unused_data;
    assign unused_data = ^data;

    AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire && sof && !eol |=> running) else $error("running not set"); // R8
    AST_CKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && eol) |=> $stable(cksum)) else $error("checksum moved mid-line"); // R9

endmodule

// File: rtl/bayer_blc.sv
module bayer_blc
    import blc_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int OUT_W   = 12,
    parameter int SCL_W   = 18,
    parameter bit REFLECT = 1'b1,
    parameter int ADDR_W  = 8,
    parameter int DIM_W   = 16,
    parameter int DEF_W   = 640,
    parameter int DEF_H   = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [IN_W-1:0]   s_data,
    input  logic              s_sof,
    input  logic              s_eol,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [OUT_W-1:0]  m_data,
    output logic              m_sof,
    output logic              m_eol,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic                          s_fire, m_fire, frame_start;
    blc_ctrl_t                     use_ctrl;
    logic [NUM_CH-1:0][IN_W-1:0]   use_ped;
    logic [NUM_CH-1:0][SCL_W-1:0]  use_scl;
    logic [DIM_W-1:0]              img_height;
    logic [1:0]                    ch;
    logic                          running;
    logic [7:0]                    cksum;

    assign s_fire      = s_valid && s_ready;
    assign m_fire      = m_valid && m_ready;
    assign frame_start = s_fire && s_sof;

    blc_regs #(
        .IN_W(IN_W), .SCL_W(SCL_W), .ADDR_W(ADDR_W),
        .DIM_W(DIM_W), .DEF_W(DEF_W), .DEF_H(DEF_H)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_start(frame_start), .stat_running(running), .stat_cksum(cksum),
        .use_ctrl(use_ctrl), .use_ped(use_ped), .use_scl(use_scl), .img_height(img_height)
    );

    blc_chan u_chan (
        .clk(clk), .rst_n(rst_n), .fire(s_fire), .sof(s_sof), .eol(s_eol),
        .phase(use_ctrl.phase), .ch(ch)
    );

    blc_correct #(
        .IN_W(IN_W), .OUT_W(OUT_W), .SCL_W(SCL_W), .REFLECT(REFLECT)
    ) u_correct (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
        .ped(use_ped[ch]), .scl(use_scl[ch]), .ctrl(use_ctrl),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol)
    );

    blc_frame_mon #(
        .OUT_W(OUT_W), .DIM_W(DIM_W), .CK_W(8)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .fire(m_fire), .sof(m_sof), .eol(m_eol),
        .data(m_data), .height(img_height), .running(running), .cksum(cksum)
    );

    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready == (!m_valid || m_ready)) else $error("ready rule broken"); // R10

endmodule

// File: tb/sim_bayer_blc.sv
`timescale 1ns/1ps
module sim_bayer_blc;

    localparam int FH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0;
    logic [11:0] s_data = '0;
    logic        s_ready;
    logic        m_valid, m_sof, m_eol;
    logic        m_ready = 1'b0;
    logic [11:0] m_data;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #10 clk = ~clk;

    bayer_blc u0 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int sh_ped[4], sh_scl[4], ac_ped[4], ac_scl[4];
    int sh_ctl = 0, ac_ctl = 0, pend = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pix(int pix, int ped, int scl, int ctl);
        longint d, r;
        if ((ctl & 1) != 0) return pix;
        d = pix - ped;
        if (d < 0) d = ((ctl & 8) != 0) ? 0 : -d;
        r = (d * scl + 131072) >>> 18;
        if (r > 4095) r = 4095;
        return int'(r);
    endfunction

    task automatic reg_wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 'h18) sh_ctl = d & 15;
        else if (a == 'h14) pend = 1;
        else if (a >= 'h20 && a < 'h40) begin
            if ((a & 4) != 0) sh_scl[(a - 'h20) >> 3] = d & 32'h3FFFF;
            else              sh_ped[(a - 'h20) >> 3] = d & 32'hFFF;
        end
    endtask

    task automatic reg_rd(input int a, output int v);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'(a);
        #1 v = int'(reg_rdata);
    endtask

    function automatic int gen_pix(int mode);
        if (mode == 1) return int'($urandom_range(7));
        if (mode == 2) return 1900 + int'($urandom_range(300));
        return int'($urandom_range(4095));
    endfunction

    // streams one frame of FH lines, each w pixels; checks every output
    task automatic run_frame(input int w, input int commit_at, input int stall_pct,
                             input int mode, input string tag);
        int n, idx, outn, sum, e, r, c, ch, v, cur;
        bit cmt, rchk;
        int exq[$];
        n = w * FH; idx = 0; outn = 0; sum = 0; cmt = 0; rchk = 0;
        cur = gen_pix(mode);
        while (outn < n) begin
            @(negedge clk);
            m_ready  = (int'($urandom_range(99)) >= stall_pct);
            reg_we   = 1'b0;
            reg_addr = 8'h0C;
            if (commit_at >= 0 && idx == commit_at && !cmt) begin
                reg_we = 1'b1; reg_addr = 8'h14; cmt = 1;
            end
            if (idx < n) begin
                r = idx / w; c = idx % w;
                s_valid = (int'($urandom_range(3)) != 0);
                s_data  = 12'(cur);
                s_sof   = (idx == 0);
                s_eol   = (c == w - 1);
            end else begin
                s_valid = 1'b0;
            end
            #1;
            if (outn >= 1 && !rchk && !reg_we) begin
                check(reg_rdata[0] == 1'b1, "R8 running mid-frame", int'(reg_rdata[0]), 1);
                rchk = 1;
            end
            if (m_valid && m_ready) begin
                e = exq.pop_front();
                v = int'(m_data) | (int'(m_sof) << 16) | (int'(m_eol) << 17);
                check(v == e, tag, v, e);
                sum = (sum + (e & 16'hFFFF)) & 255;
                outn++;
            end
            if (s_valid && s_ready) begin
                r = idx / w; c = idx % w;
                if (idx == 0 && pend != 0) begin
                    ac_ped = sh_ped; ac_scl = sh_scl; ac_ctl = sh_ctl; pend = 0;
                end
                ch = (((r & 1) << 1) | (c & 1)) ^ ((ac_ctl >> 1) & 3);
                e = exp_pix(cur, ac_ped[ch], ac_scl[ch], ac_ctl);
                exq.push_back(e | ((idx == 0) ? (1 << 16) : 0) | ((c == w - 1) ? (1 << 17) : 0));
                idx++;
                cur = gen_pix(mode);
            end
            if (reg_we) pend = 1;
        end
        @(negedge clk);
        s_valid = 1'b0; reg_we = 1'b0; m_ready = 1'b1;
        reg_rd('h0C, v);
        check((v & 1) == 0, "R8 running clear after frame", v & 1, 0);
        check(((v >> 1) & 1) == pend, "R7 pending flag after frame", (v >> 1) & 1, pend);
        reg_rd('h10, v);
        check(v == sum, "R9 frame checksum", v, sum);
    endtask

    task automatic set_ch(input int c, input int ped, input int scl);
        reg_wr('h20 + 8 * c, ped);
        reg_wr('h24 + 8 * c, scl);
    endtask

    initial begin
        int v, seed;
        seed = int'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
        check(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);
        reg_rd('h0C, v);
        check(v == 0, "R1 status after reset", v, 0);
        reg_rd('h00, v);
        check(v == 32'h6FA70177, "R1 identification", v, 32'h6FA70177);

        // R11 geometry registers
        reg_wr('h04, 'h1234);
        reg_rd('h04, v);
        check(v == 'h1234, "R11 width readback", v, 'h1234);
        reg_wr('h08, FH);
        reg_rd('h08, v);
        check(v == FH, "R11 height readback", v, FH);

        // R3 distinct channels, commit, then a frame
        set_ch(0, 100, 'h3FFFF); set_ch(1, 600, 'h20000);
        set_ch(2, 1100, 'h30000); set_ch(3, 1600, 'h10001);
        reg_wr('h18, 0);
        reg_wr('h14, 1);
        reg_rd('h0C, v);
        check(((v >> 1) & 1) == 1, "R6 pending after commit", (v >> 1) & 1, 1);
        run_frame(6, -1, 20, 0, "R3 scaled pixel");

        // R3 rounding half up on tiny values
        set_ch(0, 0, 'h20000); set_ch(1, 0, 'h20000);
        set_ch(2, 1, 'h18000); set_ch(3, 0, 'h2AAAA);
        reg_wr('h14, 1);
        run_frame(5, -1, 0, 1, "R3 rounding pixel");

        // R6 shadow only: no commit, old settings stay
        set_ch(0, 4000, 'h12345); set_ch(1, 3000, 'h3FFFF);
        reg_rd('h0C, v);
        check(((v >> 1) & 1) == 0, "R6 no pending without commit", (v >> 1) & 1, 0);
        run_frame(7, -1, 30, 0, "R6 pixel before commit");
        // R6 commit mid-frame: rest of frame unchanged, next frame new
        run_frame(8, 13, 10, 0, "R6 pixel mid-frame commit");
        run_frame(8, -1, 10, 0, "R6 pixel after commit");

        // R2 all four phases with distinct channels
        set_ch(0, 50, 'h3FFFF); set_ch(1, 900, 'h3FFFF);
        set_ch(2, 1800, 'h3FFFF); set_ch(3, 2700, 'h3FFFF);
        for (int ph = 0; ph < 4; ph++) begin
            reg_wr('h18, ph << 1);
            reg_wr('h14, 1);
            run_frame(3 + ph, -1, 25, 0, "R2 channel selection");
        end

        // R4 reflect then clip with pedestals above the samples
        for (int k = 0; k < 4; k++) set_ch(k, 2100 + 20 * k, 'h3FFFF);
        reg_wr('h18, 0); reg_wr('h14, 1);
        run_frame(6, -1, 15, 2, "R4 reflect below pedestal");
        reg_wr('h18, 8); reg_wr('h14, 1);
        run_frame(6, -1, 15, 2, "R4 clip below pedestal");

        // R5 bypass
        reg_wr('h18, 1 | (3 << 1)); reg_wr('h14, 1);
        run_frame(9, -1, 20, 0, "R5 bypass pixel");

        // R10 random settings with heavy stalls
        for (int f = 0; f < 10; f++) begin
            for (int k = 0; k < 4; k++) set_ch(k, int'($urandom_range(4095)), int'($urandom_range(32'h3FFFF)));
            reg_wr('h18, int'($urandom_range(15)));
            reg_wr('h14, 1);
            run_frame(2 + int'($urandom_range(8)), -1, 50, int'($urandom_range(2)), "R10 random frame pixel");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule